// File: doc/BRIEF.md
# Adder-Based Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit for an N-bit datapath (N defaults to 4). Eight arithmetic operations share one unsigned ripple adder. Four bitwise logic operations run beside it. A 4-bit operation select picks the result. The top select bit chooses between the two halves, and both halves evaluate at all times.

The adder always takes operand X on one input. Its carry-in is select bit 0. Its other input is built bit by bit from Y under select bits 2 and 1. That one input stage is enough to produce every arithmetic operation: transfer, increment, add, add with carry, ones-complement difference, twos-complement difference and decrement. The block also gives a carry-out and a signed-overflow indication. Both are held at zero whenever a logic operation is selected.

Top module: `addsel_alu`

## Requirements
- R1: With op_sel[3]=0, the adder computes M + opd_x + op_sel[0] modulo 2^N, where M depends on op_sel[2:1]: 00 gives zero, 01 gives opd_y, 10 gives ~opd_y and 11 gives all-ones. Codes 0000 and 0001 therefore return X and X+1.
- R2: Code 0010 returns X+Y and code 0011 returns X+Y+1, both truncated to N bits.
- R3: Code 0100 returns X+~Y, the ones-complement difference. Code 0101 returns X−Y in twos complement.
- R4: Code 0110 returns X−1, with carry_out=1 for every nonzero X and carry_out=0 for X=0. Code 0111 returns X unchanged, with carry_out=1.
- R5: With op_sel[3]=1, op_sel[2] has no effect and op_sel[1:0] selects the logic result: 00 is X AND Y, 01 is X OR Y, 10 is X XOR Y, 11 is NOT X.
- R6: For arithmetic codes, carry_out is the carry out of adder bit N−1, so that {carry_out, result} equals M + X + op_sel[0] exactly.
- R7: For logic codes, carry_out is 0.
- R8: For arithmetic codes, ovf is 1 exactly when the sign bits of M and X are equal and the sign bit of result differs from them. For logic codes, ovf is 0.
- R9: The block has no clock and no storage. Every output follows a change of any input within the same evaluation, so no clock edge is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_x | input | N | First operand. It always feeds the adder directly. |
| opd_y | input | N | Second operand. It is conditioned into the adder's other input. |
| op_sel | input | 4 | Operation select. Bit 3 selects logic (1) or arithmetic (0). |
| result | output | N | Selected result. |
| carry_out | output | 1 | Adder carry from the top bit. It is 0 for logic codes. |
| ovf | output | 1 | Signed overflow of the adder. It is 0 for logic codes. |

## Verification
Every result is due zero cycles after its stimulus, because no register lies anywhere between the ports. The bench therefore changes the inputs, waits one nanosecond with no clock edge involved, and then compares result, carry_out and ovf. It does this first for a table of hand-computed vectors and then for every combination of select code and operand values. The expected values come from a model written from the opcode map and the overflow rule. Directed checks then cover the two transfer codes, decrement with its carry, and the unused select bit of the logic half.

// File: rtl/addsel_alu_pkg.sv
// Shared types for the adder-based ALU.
// Assumes the select code is 4 bits wide. The bit positions are fixed,
// because each bit drives its own part of the datapath.
package addsel_alu_pkg;

    localparam int SEL_W = 4;

    // Operation select, viewed field by field.
    typedef struct packed {
        logic unit_logic;   // 1 selects the logic half
        logic m_inv;        // feed ~Y into the adder's conditioned input
        logic m_pass;       // feed Y into the adder's conditioned input
        logic cin;          // adder carry-in
    } sel_t;

    // Logic-half operations, taken from the two low select bits.
    typedef enum logic [1:0] {
        LOP_AND  = 2'b00,
        LOP_OR   = 2'b01,
        LOP_XOR  = 2'b10,
        LOP_NOTX = 2'b11
    } lop_t;

endpackage

// File: rtl/addsel_alu_mopnd.sv
// Conditioned adder operand.
// Each bit of the output is (inv & ~y) | (pass & y). Together the two
// controls give zero, Y, ~Y or all-ones.
// Assumes nothing about the operand width beyond N >= 1.
module addsel_alu_mopnd #(
    parameter int N = 4
) (
    input  logic [N-1:0] y_in,
    input  logic         m_inv,
    input  logic         m_pass,
    output logic [N-1:0] m_out
);

    for (genvar b = 0; b < N; b++) begin : g_bit
        // Per-bit gate form of the four-way operand choice.
        always_comb m_out[b] = (m_inv & ~y_in[b]) | (m_pass & y_in[b]);
    end

endmodule

// File: rtl/addsel_alu_adder.sv
// Unsigned N-bit ripple adder, sum = a + b + cin.
// It gives the carry out of the top bit for the carry output.
// Assumes N >= 1. Its depth is N full-adder stages.
module addsel_alu_adder #(
    parameter int N = 4
) (
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] b_in,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);

    logic [N:0] c;

    // The carry chain starts at the external carry-in.
    always_comb c[0] = cin;

    for (genvar b = 0; b < N; b++) begin : g_fa
        // One full-adder stage: sum bit and ripple carry.
        always_comb begin
            sum[b]   = a_in[b] ^ b_in[b] ^ c[b];
            c[b + 1] = (a_in[b] & b_in[b]) | (c[b] & (a_in[b] ^ b_in[b]));
        end
    end

    // Carry leaving the most significant stage.
    always_comb cout = c[N];

endmodule

// File: rtl/addsel_alu_lunit.sv
// Bitwise logic half: AND, OR, XOR, or NOT of X, chosen by a 2-bit code.
// Assumes the caller passes only the two low select bits.
module addsel_alu_lunit
    import addsel_alu_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] x_in,
    input  logic [N-1:0] y_in,
    input  lop_t         lop,
    output logic [N-1:0] l_out
);

    for (genvar b = 0; b < N; b++) begin : g_bit
        // Per-bit four-way choice of the primitive operation.
        always_comb begin
            unique case (lop)
                LOP_AND:  l_out[b] = x_in[b] & y_in[b];
                LOP_OR:   l_out[b] = x_in[b] | y_in[b];
                LOP_XOR:  l_out[b] = x_in[b] ^ y_in[b];
                default:  l_out[b] = ~x_in[b];
            endcase
        end
    end

endmodule

// File: rtl/addsel_alu.sv
// Top level of the adder-based ALU.
// Both halves evaluate at all times, and select bit 3 picks which one
// drives the result. Carry and overflow are held at 0 for logic codes.
// The block is purely combinational: it has no clock, no reset and no state.
module addsel_alu
    import addsel_alu_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0]     opd_x,
    input  logic [N-1:0]     opd_y,
    input  logic [SEL_W-1:0] op_sel,
    output logic [N-1:0]     result,
    output logic             carry_out,
    output logic             ovf
);

    localparam int MSB = N - 1;

    sel_t         sel;
    logic [N-1:0] m_opnd;
    logic [N-1:0] a_sum;
    logic         a_cout;
    logic [N-1:0] l_res;
    lop_t         lop;

    // Split the select code into its control fields.
    always_comb begin
        sel = sel_t'(op_sel);
        lop = lop_t'(op_sel[1:0]);
    end

    addsel_alu_mopnd #(.N(N)) u_mopnd (
        .y_in   (opd_y),
        .m_inv  (sel.m_inv),
        .m_pass (sel.m_pass),
        .m_out  (m_opnd)
    );

    addsel_alu_adder #(.N(N)) u_adder (
        .a_in (m_opnd),
        .b_in (opd_x),
        .cin  (sel.cin),
        .sum  (a_sum),
        .cout (a_cout)
    );

    addsel_alu_lunit #(.N(N)) u_lunit (
        .x_in  (opd_x),
        .y_in  (opd_y),
        .lop   (lop),
        .l_out (l_res)
    );

    // Output multiplexer, plus the flags gated to arithmetic codes.
    always_comb begin
        if (sel.unit_logic) begin
            result    = l_res;
            carry_out = 1'b0;
            ovf       = 1'b0;
        end else begin
            result    = a_sum;
            carry_out = a_cout;
            ovf       = (m_opnd[MSB] == opd_x[MSB]) && (a_sum[MSB] != opd_x[MSB]);
        end
    end

endmodule

// File: rtl/addsel_alu_chk.sv
// Checker for the ALU, attached to it by bind.
// It uses immediate assertions only, because the block has no clock.
// It observes ports only.
module addsel_alu_chk #(
    parameter int N = 4
) (
    input logic [N-1:0] opd_x,
    input logic [N-1:0] opd_y,
    input logic [3:0]   op_sel,
    input logic [N-1:0] result,
    input logic         carry_out,
    input logic         ovf
);

    // Port relations that must hold on every evaluation.
    always_comb begin
        if (op_sel[3]) begin
            p_logic_no_carry_r7: assert (carry_out == 1'b0);
            p_logic_no_ovf_r8:   assert (ovf == 1'b0);
        end
        if (op_sel == 4'b0000) begin
            p_transfer_low_r1: assert (result == opd_x && !carry_out);
        end
        if (op_sel == 4'b0111) begin
            p_transfer_high_r4: assert (result == opd_x && carry_out);
        end
        if (op_sel == 4'b0110 && opd_x != '0) begin
            p_decr_carry_r4: assert (carry_out == 1'b1);
        end
        if (op_sel[3] && op_sel[1:0] == 2'b11) begin
            p_not_x_r5: assert (result == ~opd_x);
        end
        if (op_sel == 4'b0010) begin
            p_add_wide_r6: assert ({carry_out, result} == {1'b0, opd_x} + {1'b0, opd_y});
        end
    end

endmodule

bind addsel_alu addsel_alu_chk #(.N(N)) u_chk (
    .opd_x     (opd_x),
    .opd_y     (opd_y),
    .op_sel    (op_sel),
    .result    (result),
    .carry_out (carry_out),
    .ovf       (ovf)
);

// File: tb/addsel_alu_bench.sv
// Self-checking bench for addsel_alu at N=4.
// It walks a table of hand-computed vectors, then sweeps every select code
// and every operand pair against a model, then runs directed corner checks.
module addsel_alu_bench;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic [N-1:0] opd_x = '0;
    logic [N-1:0] opd_y = '0;
    logic [3:0]   op_sel = '0;
    logic [N-1:0] result;
    logic         carry_out;
    logic         ovf;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // 200 MHz clock, used here only to pace the watchdog.
    always #2.5 clk = ~clk;

    addsel_alu #(.N(N)) u_addsel_alu (
        .opd_x     (opd_x),
        .opd_y     (opd_y),
        .op_sel    (op_sel),
        .result    (result),
        .carry_out (carry_out),
        .ovf       (ovf)
    );

    // Vector layout: {sel[3:0], x[3:0], y[3:0], g[3:0], co}
    localparam logic [16:0] VEC [14] = '{
        {4'b0000, 4'h5, 4'h9, 4'h5, 1'b0},  // R1 transfer
        {4'b0001, 4'hF, 4'h0, 4'h0, 1'b1},  // R1 increment wraps
        {4'b0010, 4'h9, 4'h8, 4'h1, 1'b1},  // R2 add with carry out
        {4'b0011, 4'h3, 4'h4, 4'h8, 1'b0},  // R2 add plus one
        {4'b0100, 4'h6, 4'h2, 4'h3, 1'b1},  // R3 ones-complement difference
        {4'b0101, 4'h6, 4'h2, 4'h4, 1'b1},  // R3 X-Y, no borrow
        {4'b0101, 4'h2, 4'h6, 4'hC, 1'b0},  // R3 X-Y, borrow
        {4'b0110, 4'h0, 4'h5, 4'hF, 1'b0},  // R4 decrement of zero
        {4'b0110, 4'h7, 4'h5, 4'h6, 1'b1},  // R4 decrement
        {4'b0111, 4'hA, 4'h3, 4'hA, 1'b1},  // R4 second transfer
        {4'b1000, 4'hC, 4'hA, 4'h8, 1'b0},  // R5 AND
        {4'b1101, 4'hC, 4'hA, 4'hE, 1'b0},  // R5 OR, bit 2 set
        {4'b1010, 4'hC, 4'hA, 4'h6, 1'b0},  // R5 XOR
        {4'b1111, 4'hC, 4'hA, 4'h3, 1'b0}   // R5 NOT X
    };

    // Model built from the opcode map: {ovf, co, g}.
    function automatic logic [N+1:0] model(input logic [N-1:0] x,
                                           input logic [N-1:0] y,
                                           input logic [3:0]   s);
        logic [N-1:0] m;
        logic [N:0]   wide;
        logic         v;
        if (s[3]) begin
            case (s[1:0])
                2'b00:   return {2'b00, x & y};
                2'b01:   return {2'b00, x | y};
                2'b10:   return {2'b00, x ^ y};
                default: return {2'b00, ~x};
            endcase
        end
        case (s[2:1])
            2'b00:   m = '0;
            2'b01:   m = y;
            2'b10:   m = ~y;
            default: m = '1;
        endcase
        wide = {1'b0, m} + {1'b0, x} + {{N{1'b0}}, s[0]};
        v = (m[N-1] == x[N-1]) && (wide[N-1] != x[N-1]);
        return {v, wide[N], wide[N-1:0]};
    endfunction

    task automatic check(input string req, input logic [N+1:0] act, input logic [N+1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s sel=%b x=%h y=%h actual={v,co,g}=%b expected=%b",
                     req, op_sel, opd_x, opd_y, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] s, input logic [N-1:0] x, input logic [N-1:0] y);
        op_sel = s;
        opd_x  = x;
        opd_y  = y;
        #1;  // results are due in the same evaluation, with no clock edge
    endtask

    initial begin
        #1;
        // R9: the initial all-zero inputs give a transfer of 0.
        check("R9", {ovf, carry_out, result}, '0);

        // Table walk, R1 to R5
        foreach (VEC[i]) begin
            apply(VEC[i][16:13], VEC[i][12:9], VEC[i][8:5]);
            n_checks++;
            if ({carry_out, result} !== {VEC[i][0], VEC[i][4:1]}) begin
                n_fails++;
                $display("FAIL R1-5 table entry %0d actual co,g=%b,%h expected=%b,%h",
                         i, carry_out, result, VEC[i][0], VEC[i][4:1]);
            end
        end

        // Exhaustive sweep: R6 carry, R7 and R8 flags, all codes
        for (int s = 0; s < 16; s++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    apply(4'(s), 4'(x), 4'(y));
                    check(s >= 8 ? "R7_R8" : "R6_R8", {ovf, carry_out, result},
                          model(4'(x), 4'(y), 4'(s)));
                end
            end
        end

        // R4: decrement carries for every nonzero X, and code 0111 returns X.
        for (int x = 1; x < 16; x++) begin
            apply(4'b0110, 4'(x), 4'h0);
            check("R4", {1'b0, carry_out, 4'b0}, {1'b0, 1'b1, 4'b0});
            apply(4'b0111, 4'(x), 4'h9);
            check("R4", {2'b00, result}, {2'b00, 4'(x)});
        end

        // R5: bit 2 has no effect on the logic half.
        for (int c = 0; c < 4; c++) begin
            apply({2'b10, 2'(c)}, 4'h6, 4'hB);
            begin
                logic [N+1:0] lo;
                lo = {ovf, carry_out, result};
                apply({2'b11, 2'(c)}, 4'h6, 4'hB);
                check("R5", {ovf, carry_out, result}, lo);
            end
        end

        // R8: 7+1 overflows, and -8-1 via X-Y overflows.
        apply(4'b0001, 4'h7, 4'h0);
        check("R8", {ovf, 1'b0, 4'h0}, {1'b1, 1'b0, 4'h0});
        apply(4'b0101, 4'h8, 4'h1);
        check("R8", {ovf, 1'b0, result}, {1'b1, 1'b0, 4'h7});

        // R9: an input change alone updates the result.
        apply(4'b0010, 4'h1, 4'h1);
        opd_y = 4'h2;
        #1;
        check("R9", {2'b00, result}, {2'b00, 4'h3});

        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        for (int k = 0; k < 100000 && !done; k++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule